// File: doc/BRIEF.md
# LCD Colour Palette Lookup Table

This block holds the colour lookup table of an LCD controller. Each of its 256 entries is an 18-bit colour with three 6-bit components. The display path presents an 8-bit pixel code every cycle and receives the matching colour one clock later. A CPU reaches the table through a pair of registers. One is an index word that names an entry and selects an access mode. The other is a data register that reads or writes the entry that word points at.

In single mode, every data access touches the same entry. In sequential mode, an internal pointer starts at entry 0 and steps after each data access. This lets software save or reload the whole table with 256 back-to-back data accesses. Software can read the index word back, so it can restore the word after such a walk.

Palette accesses through the data register only take effect while the LCD clock enable is high. A CPU write and a display lookup may land in the same cycle. The display port then sees the colour the entry held before that write.

Top module: `lcd_clut`

## Requirements
- R1: Each entry packs red in bits 17:12, green in bits 11:6 and blue in bits 5:0. The display port returns on `pix_color` the entry named by `pix_code`, registered one clock after the code is presented.
- R2: After the index word is written with bits 9:8 = 00 and an entry number in bits 7:0, a data write stores `cpu_wdata[17:0]` into that entry. A data read returns that entry in `cpu_rdata[17:0]`, with bits 31:18 zero, on the clock that takes the read.
- R3: Writing the index word with bits 9:8 = 11 selects sequential mode and points at entry 0, whatever bits 7:0 hold. Each accepted data read or write then advances the pointer by one, and the pointer wraps from 255 to 0.
- R4: In single mode (bits 9:8 = 00), data accesses leave the pointer where it is, so repeated accesses reach the same entry.
- R5: A read of the index register (`cpu_reg` = 0) returns the last written index bits 9:0 zero-extended to 32 bits. Written bits 31:10 are dropped.
- R6: While `lcd_clk_en` is low, data writes change no entry, data reads return 0 and the pointer does not move. The index register stays readable and writable.
- R7: Index modes 01 and 10 are invalid. In those modes, data writes change no entry, data reads return 0 and the pointer does not move.
- R8: When a CPU data write and a display lookup hit the same entry on the same clock, `pix_color` shows the previous value. The new value appears on the next lookup.
- R9: Reset clears the index word to 0 (single mode, entry 0), `cpu_rdata` to 0 and `pix_color` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcd_clk_en | input | 1 | LCD clock enable; gates data-register accesses |
| cpu_sel | input | 1 | CPU access strobe, one access per asserted cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 1 | 0 = index register, 1 = data register |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, updated on the clock that takes a read |
| pix_code | input | 8 | Pixel code from the display path |
| pix_color | output | 18 | Looked-up 6:6:6 colour, one clock after `pix_code` |

## Verification
The assertions assume that `cpu_sel` frames a single access per cycle and that `cpu_we` and `cpu_reg` are stable while it is high. They also assume that `lcd_clk_en` only changes between accesses. The bench drives every input on the falling edge. It raises `cpu_sel` for exactly one cycle per access and toggles `lcd_clk_en` only while the strobe is low. Collisions with the display port are created on purpose by holding `pix_code` on the written entry during the write cycle.

// File: rtl/lcd_clut_pkg.sv
package lcd_clut_pkg;

  // Access mode carried in the two bits above the entry number.
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_BAD_A  = 2'b01,
    MODE_BAD_B  = 2'b10,
    MODE_SEQ    = 2'b11
  } clut_mode_e;

  function automatic logic mode_is_valid(input logic [1:0] m);
    return (m == MODE_SINGLE) || (m == MODE_SEQ);
  endfunction

  function automatic logic mode_is_seq(input logic [1:0] m);
    return m == MODE_SEQ;
  endfunction

endpackage

// File: rtl/lcd_clut_regs.sv
module lcd_clut_regs #(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lcd_clk_en,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic               cpu_reg,
  input  logic [BUS_W-1:0]   cpu_wdata,
  output logic [IDX_W+1:0]   idx_word,
  output logic [IDX_W-1:0]   ptr,
  output logic               idx_wr,
  output logic               data_acc,
  output logic               mode_ok,
  output logic               seq_mode
);
  import lcd_clut_pkg::*;

  localparam int WORD_W = IDX_W + 2;

  logic [1:0] new_mode;

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return p + 1'b1;
  endfunction

  assign idx_wr   = cpu_sel && cpu_we && !cpu_reg;
  assign new_mode = cpu_wdata[WORD_W-1:IDX_W];
  assign mode_ok  = mode_is_valid(idx_word[WORD_W-1:IDX_W]);
  assign seq_mode = mode_is_seq(idx_word[WORD_W-1:IDX_W]);
  assign data_acc = cpu_sel && cpu_reg && lcd_clk_en && mode_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_word <= '0;
      ptr      <= '0;
    end else if (idx_wr) begin
      idx_word <= cpu_wdata[WORD_W-1:0];
      ptr      <= mode_is_seq(new_mode) ? '0 : cpu_wdata[IDX_W-1:0];
    end else if (data_acc && seq_mode) begin
      ptr <= step_ptr(ptr);
    end
  end

endmodule

// File: rtl/lcd_clut_ram.sv
module lcd_clut_ram #(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   cpu_addr,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] cpu_q,
  input  logic [IDX_W-1:0]   pix_addr,
  output logic [ENTRY_W-1:0] pix_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[cpu_addr] <= wdata;
  end

  // Display port samples the array before this edge's write lands.
  always_ff @(posedge clk) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= mem[pix_addr];
  end

  assign cpu_q = mem[cpu_addr];

endmodule

// File: rtl/lcd_clut.sv
module lcd_clut #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lcd_clk_en,
  input  logic                  cpu_sel,
  input  logic                  cpu_we,
  input  logic                  cpu_reg,
  input  logic [BUS_W-1:0]      cpu_wdata,
  output logic [BUS_W-1:0]      cpu_rdata,
  input  logic [IDX_W-1:0]      pix_code,
  output logic [3*COMP_W-1:0]   pix_color
);
  localparam int ENTRY_W = 3 * COMP_W;
  localparam int WORD_W  = IDX_W + 2;

  logic [WORD_W-1:0]  idx_word;
  logic [IDX_W-1:0]   ptr;
  logic               idx_wr;
  logic               data_acc;
  logic               mode_ok;
  logic               seq_mode;
  logic               ram_we;
  logic               cpu_rd;
  logic [ENTRY_W-1:0] cpu_q;

  function automatic logic [BUS_W-1:0] widen_entry(input logic [ENTRY_W-1:0] e);
    return {{(BUS_W-ENTRY_W){1'b0}}, e};
  endfunction

  function automatic logic [BUS_W-1:0] widen_index(input logic [WORD_W-1:0] w);
    return {{(BUS_W-WORD_W){1'b0}}, w};
  endfunction

  lcd_clut_regs #(.IDX_W(IDX_W), .BUS_W(BUS_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcd_clk_en (lcd_clk_en),
    .cpu_sel    (cpu_sel),
    .cpu_we     (cpu_we),
    .cpu_reg    (cpu_reg),
    .cpu_wdata  (cpu_wdata),
    .idx_word   (idx_word),
    .ptr        (ptr),
    .idx_wr     (idx_wr),
    .data_acc   (data_acc),
    .mode_ok    (mode_ok),
    .seq_mode   (seq_mode)
  );

  assign ram_we = data_acc && cpu_we;
  assign cpu_rd = cpu_sel && !cpu_we;

  lcd_clut_ram #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) ram_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ram_we),
    .cpu_addr (ptr),
    .wdata    (cpu_wdata[ENTRY_W-1:0]),
    .cpu_q    (cpu_q),
    .pix_addr (pix_code),
    .pix_q    (pix_color)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
    end else if (cpu_rd) begin
      if (!cpu_reg)      cpu_rdata <= widen_index(idx_word);
      else if (data_acc) cpu_rdata <= widen_entry(cpu_q);
      else               cpu_rdata <= '0;
    end
  end

endmodule

// File: rtl/lcd_clut_chk.sv
module lcd_clut_chk #(
  parameter int IDX_W = 8,
  parameter int BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lcd_clk_en,
  input logic               cpu_sel,
  input logic               cpu_we,
  input logic               cpu_reg,
  input logic [BUS_W-1:0]   cpu_wdata,
  input logic [BUS_W-1:0]   cpu_rdata,
  input logic [IDX_W-1:0]   ptr,
  input logic               idx_wr,
  input logic               data_acc,
  input logic               mode_ok,
  input logic               seq_mode,
  input logic               ram_we
);

  assert_seq_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && cpu_wdata[IDX_W+1:IDX_W] == 2'b11) |=> (ptr == '0));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && seq_mode) |=> (ptr == IDX_W'($past(ptr) + 1'b1)));

  assert_single_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !seq_mode) |=> $stable(ptr));

  assert_idx_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && !cpu_reg) |=> (cpu_rdata[BUS_W-1:IDX_W+2] == '0));

  assert_clk_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_clk_en |-> !ram_we);

  assert_clk_gate_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && cpu_reg && !lcd_clk_en) |=> (cpu_rdata == '0));

  assert_bad_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && cpu_reg && !mode_ok) |=> (cpu_rdata == '0));

  assert_bad_mode_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_reg && !mode_ok) |=> $stable(ptr));

endmodule

bind lcd_clut lcd_clut_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcd_clk_en (lcd_clk_en),
  .cpu_sel    (cpu_sel),
  .cpu_we     (cpu_we),
  .cpu_reg    (cpu_reg),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .ptr        (ptr),
  .idx_wr     (idx_wr),
  .data_acc   (data_acc),
  .mode_ok    (mode_ok),
  .seq_mode   (seq_mode),
  .ram_we     (ram_we)
);

// File: tb/lcd_clut_tb.sv
module lcd_clut_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcd_clk_en = 1'b1;
  logic        cpu_sel = 1'b0;
  logic        cpu_we = 1'b0;
  logic        cpu_reg = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [7:0]  pix_code = '0;
  logic [17:0] pix_color;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcd_clut dut_i (
    .clk(clk), .rst_n(rst_n), .lcd_clk_en(lcd_clk_en),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_reg(cpu_reg),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pix_code(pix_code), .pix_color(pix_color)
  );

  // Vector: kind (1 = check read), reg select, write data, expected, tag number.
  typedef struct packed {
    logic        chk;
    logic        rg;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0005, 32'h0,        8'd2}, // R2 index -> entry 5
    '{1'b0, 1'b1, 32'hFFF2_ABCD, 32'h0,        8'd2}, // R2 upper bits dropped
    '{1'b1, 1'b1, 32'h0,         32'h0002_ABCD, 8'd2}, // R2 read back
    '{1'b1, 1'b0, 32'h0,         32'h0000_0005, 8'd5}, // R5 index readback
    '{1'b0, 1'b0, 32'hFFFF_F0A7, 32'h0,        8'd5}, // R5 upper bits dropped
    '{1'b1, 1'b0, 32'h0,         32'h0000_00A7, 8'd5}, // R5
    '{1'b0, 1'b1, 32'h0003_F000, 32'h0,        8'd1}, // R1 pure red
    '{1'b1, 1'b1, 32'h0,         32'h0003_F000, 8'd1}, // R1
    '{1'b1, 1'b1, 32'h0,         32'h0003_F000, 8'd4}, // R4 pointer held
    '{1'b0, 1'b0, 32'h0000_0355, 32'h0,        8'd3}, // R3 seq, entry bits ignored
    '{1'b0, 1'b1, 32'h0000_0001, 32'h0,        8'd3}, // R3 entry 0
    '{1'b0, 1'b1, 32'h0000_0002, 32'h0,        8'd3}, // R3 entry 1
    '{1'b0, 1'b0, 32'h0000_0300, 32'h0,        8'd3}, // R3 restart
    '{1'b1, 1'b1, 32'h0,         32'h0000_0001, 8'd3}, // R3
    '{1'b1, 1'b1, 32'h0,         32'h0000_0002, 8'd3}, // R3
    '{1'b0, 1'b0, 32'h0000_0101, 32'h0,        8'd7}, // R7 mode 01
    '{1'b0, 1'b1, 32'h0001_2345, 32'h0,        8'd7}, // R7 write ignored
    '{1'b1, 1'b1, 32'h0,         32'h0000_0000, 8'd7}, // R7 read gives 0
    '{1'b0, 1'b0, 32'h0000_0001, 32'h0,        8'd7}, // R7 back to single, entry 1
    '{1'b1, 1'b1, 32'h0,         32'h0000_0002, 8'd7}  // R7 entry 1 untouched
  };

  function automatic logic [17:0] pattern(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b[5:0], ~b[5:0], b[7:2]};
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  // One access; returns after the clock that takes it, on a falling edge.
  task automatic access(input logic we, input logic rg, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = we; cpu_reg = rg; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd_chk(input logic rg, input logic [31:0] exp, input int req);
    access(1'b0, rg, 32'h0);
    check(req, cpu_rdata, exp);
  endtask

  task automatic pix_chk(input logic [7:0] code, input logic [17:0] exp, input int req);
    @(negedge clk);
    pix_code = code;
    @(negedge clk);
    check(req, {14'h0, pix_color}, {14'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(9, cpu_rdata, 32'h0);
    check(9, {14'h0, pix_color}, 32'h0);
    rst_n = 1'b1;
    rd_chk(1'b0, 32'h0, 9); // R9 index cleared

    foreach (VECS[k]) begin
      if (VECS[k].chk) rd_chk(VECS[k].rg, VECS[k].exp, int'(VECS[k].req));
      else             access(1'b1, VECS[k].rg, VECS[k].d);
    end

    // R3 full sequential walk with wrap
    access(1'b1, 1'b0, 32'h300);
    for (int i = 0; i < 256; i++) access(1'b1, 1'b1, {14'h0, pattern(i)});
    access(1'b1, 1'b0, 32'h300);
    for (int i = 0; i < 256; i++) rd_chk(1'b1, {14'h0, pattern(i)}, 3);
    rd_chk(1'b1, {14'h0, pattern(0)}, 3); // R3 wrapped to entry 0
    rd_chk(1'b0, 32'h300, 5);              // R5 index word unchanged by walk

    // R1 display lookups
    pix_chk(8'h00, pattern(0), 1);
    pix_chk(8'h7F, pattern(127), 1);
    pix_chk(8'hFF, pattern(255), 1);

    // R6 clock gating in single mode
    access(1'b1, 1'b0, 32'h010);
    lcd_clk_en = 1'b0;
    access(1'b1, 1'b1, 32'h11111);
    rd_chk(1'b1, 32'h0, 6);
    access(1'b1, 1'b0, 32'h011);
    rd_chk(1'b0, 32'h011, 6);
    lcd_clk_en = 1'b1;
    rd_chk(1'b1, {14'h0, pattern(17)}, 6);
    access(1'b1, 1'b0, 32'h010);
    rd_chk(1'b1, {14'h0, pattern(16)}, 6); // R6 write was dropped
    // R6 pointer frozen in sequential mode
    access(1'b1, 1'b0, 32'h300);
    rd_chk(1'b1, {14'h0, pattern(0)}, 6);
    lcd_clk_en = 1'b0;
    rd_chk(1'b1, 32'h0, 6);
    lcd_clk_en = 1'b1;
    rd_chk(1'b1, {14'h0, pattern(1)}, 6);

    // R7 mode 10 also invalid
    access(1'b1, 1'b0, 32'h220);
    access(1'b1, 1'b1, 32'h2AAAA);
    rd_chk(1'b1, 32'h0, 7);
    access(1'b1, 1'b0, 32'h020);
    rd_chk(1'b1, {14'h0, pattern(32)}, 7);

    // R8 collision: write entry 0x20 while the display reads it
    @(negedge clk);
    pix_code = 8'h20;
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_reg = 1'b1; cpu_wdata = 32'h1E1E1;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
    check(8, {14'h0, pix_color}, {14'h0, pattern(32)});
    @(negedge clk);
    check(8, {14'h0, pix_color}, 32'h1E1E1);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(9, cpu_rdata, 32'h0);
    check(9, {14'h0, pix_color}, 32'h0);
    rst_n = 1'b1;
    rd_chk(1'b0, 32'h0, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

endmodule